// File: doc/BRIEF.md
# PLL Acquisition and Lock Supervisor

This block is the digital supervisor of a clock-generator PLL. It holds the control state that switches the PLL on and selects automatic or manual operation. It also holds the loop-filter mode (acquisition or tracking), the lock interrupt enable and the bus clock source select. An external frequency comparator supplies a within-tolerance level. That level passes through a two-flop synchronizer before any logic uses it.

In automatic mode the block derives a lock flag from the synchronized tolerance level. It moves the filter to tracking while locked. When the interrupt enable is set, it raises a sticky interrupt on every lock change. In manual mode software owns the filter mode. The block enforces the required order: the PLL must be switched on in acquisition, and tracking is allowed only after a programmable acquisition delay. The PLL clock may drive the bus only after a second programmable delay spent in tracking. Any write that breaks this order is refused and flagged. In manual mode lock always reads 0 and no interrupts are produced.

Software writes all control bits together in one cycle through the `wr_*` inputs. Both delays are counted in reference-clock cycles.

Top module: `pll_sup_ctrl`

## Requirements
- R1: After reset, pll_on, track, lock, irq, bcs_sel and seq_err are all 0.
- R2: In automatic mode (wr_auto = 1) with the PLL on, lock equals the within-tolerance input delayed by three clock edges (two synchronizer stages plus the lock register). Lock is 0 whenever the PLL is off.
- R3: With automatic mode and the interrupt enable at 1, every lock change (0 to 1 or 1 to 0) sets irq. With the enable at 0, lock changes leave irq at 0.
- R4: irq stays set until a cycle with irq_ack = 1 clears it.
- R5: In manual mode (wr_auto = 0), lock reads 0 and irq reads 0, whatever the tolerance input does.
- R6: In manual mode, a write that turns the PLL on with wr_track = 1 still turns the PLL on. The filter stays in acquisition (track = 0), and seq_err pulses high for one cycle.
- R7: In manual mode, a request to enter tracking is accepted only at a write edge that is at least acq_delay + 1 edges after the turn-on edge. An earlier request leaves track at 0 and pulses seq_err.
- R8: In manual mode, a request to set bcs_sel is accepted only while tracking and at a write edge at least trk_delay + 1 edges after the edge that entered tracking. Otherwise bcs_sel stays 0 and seq_err pulses.
- R9: A write with wr_pll_on = 0 clears pll_on, track and bcs_sel at that edge and lock one edge later. It also restarts both delay counts, so the next turn-on again waits the full acquisition delay.
- R10: In automatic mode track follows lock, and a bcs_sel request is accepted whenever the PLL is on.
- R11: In manual mode, writing wr_track = 0 returns the filter to acquisition and clears bcs_sel at the same edge without flagging an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Control write strobe |
| wr_pll_on | input | 1 | Written PLL enable |
| wr_auto | input | 1 | Written mode: 1 automatic, 0 manual |
| wr_track | input | 1 | Written filter mode (manual): 1 tracking, 0 acquisition |
| wr_bcs | input | 1 | Written clock-source select: 1 selects the PLL clock |
| wr_irq_en | input | 1 | Written lock interrupt enable |
| irq_ack | input | 1 | Write-one-to-clear acknowledge of irq |
| acq_delay | input | DLY_W | Acquisition delay in clock cycles |
| trk_delay | input | DLY_W | Tracking-to-select delay in clock cycles |
| in_tol | input | 1 | Asynchronous within-tolerance level from the comparator |
| pll_on | output | 1 | PLL enable |
| track | output | 1 | Filter mode: 1 tracking, 0 acquisition |
| lock | output | 1 | Lock status |
| irq | output | 1 | Sticky lock-change interrupt request |
| bcs_sel | output | 1 | Bus clock source: 1 PLL clock |
| seq_err | output | 1 | One-cycle pulse on a refused manual-mode write |

## Verification
The hardest condition to reach is the exact boundary edge of each manual delay. A tracking or clock-select request one edge too early must be refused, and the same request one edge later must be accepted. The vector table issues back-to-back writes from turn-on with short delays. The refused request lands on edge acq_delay and the accepted one lands on the next edge, and the same pattern is repeated for the tracking delay. Directed tests then revisit these windows after a power-off to show that the counts restart.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;

  // Software-visible control state held by the supervisor
  typedef struct packed {
    logic on;
    logic auto_md;
    logic trk;
    logic bcs;
    logic ie;
  } pll_ctrl_t;

  localparam int unsigned SYNC_STAGES = 2;

endpackage

// File: rtl/pll_tol_sync.sv
module pll_tol_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_async};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_sync = sh_q[STAGES-1];

endmodule

// File: rtl/pll_dly_timer.sv
module pll_dly_timer #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         done
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (!run) begin
      cnt_en = (cnt_q != '0);
      cnt_d  = '0;
    end else if (cnt_q < limit) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q >= limit);

  // R9: a stopped timer is back at zero one edge later
  a_r9_timer_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

endmodule

// File: rtl/pll_lock_irq.sv
module pll_lock_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic tol_s,
  input  logic on,
  input  logic auto_md,
  input  logic ie,
  input  logic ack,
  output logic lock_nxt,
  output logic lock_q,
  output logic irq_q
);

  logic irq_d;
  logic chg;

  always_comb begin
    lock_nxt = on & auto_md & tol_s;
    chg      = (lock_nxt != lock_q);
    irq_d    = 1'b0;
    if (auto_md) irq_d = (irq_q & ~ack) | (ie & chg);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      lock_q <= lock_nxt;
      irq_q  <= irq_d;
    end
  end

  // R5: manual mode drops lock and interrupt on the next edge
  a_r5_no_lock_manual: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_md |=> !lock_q);
  a_r5_no_irq_manual: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_md |=> !irq_q);
  // R3: an enabled lock change in automatic mode leaves irq set
  a_r3_irq_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_q != $past(lock_q)) && $past(ie && auto_md)) |-> irq_q);

endmodule

// File: rtl/pll_sup_ctrl.sv
module pll_sup_ctrl
  import pll_sup_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_pll_on,
  input  logic             wr_auto,
  input  logic             wr_track,
  input  logic             wr_bcs,
  input  logic             wr_irq_en,
  input  logic             irq_ack,
  input  logic [DLY_W-1:0] acq_delay,
  input  logic [DLY_W-1:0] trk_delay,
  input  logic             in_tol,
  output logic             pll_on,
  output logic             track,
  output logic             lock,
  output logic             irq,
  output logic             bcs_sel,
  output logic             seq_err
);

  pll_ctrl_t ctl_q, ctl_d;
  logic      err_q, err_d;
  logic      tol_s;
  logic      lock_nxt, lock_q, irq_q;
  logic      acq_done, trk_done;
  logic      turn_on;

  pll_tol_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(in_tol), .q_sync(tol_s));

  pll_lock_irq u_lock (
    .clk(clk), .rst_n(rst_n), .tol_s(tol_s), .on(ctl_q.on),
    .auto_md(ctl_q.auto_md), .ie(ctl_q.ie), .ack(irq_ack),
    .lock_nxt(lock_nxt), .lock_q(lock_q), .irq_q(irq_q));

  pll_dly_timer #(.W(DLY_W)) u_acq_tmr (
    .clk(clk), .rst_n(rst_n), .run(ctl_q.on),
    .limit(acq_delay), .done(acq_done));

  pll_dly_timer #(.W(DLY_W)) u_trk_tmr (
    .clk(clk), .rst_n(rst_n),
    .run(ctl_q.on & ctl_q.trk & ~ctl_q.auto_md),
    .limit(trk_delay), .done(trk_done));

  always_comb begin
    ctl_d   = ctl_q;
    err_d   = 1'b0;
    turn_on = 1'b0;
    if (ctl_q.auto_md) ctl_d.trk = lock_nxt;
    if (wr_en) begin
      ctl_d.on      = wr_pll_on;
      ctl_d.auto_md = wr_auto;
      ctl_d.ie      = wr_irq_en;
      if (wr_auto) begin
        ctl_d.trk = lock_nxt;
        ctl_d.bcs = wr_bcs;
      end else begin
        turn_on = ~ctl_q.on & wr_pll_on;
        if (wr_track && !ctl_q.trk) begin
          if (turn_on || !acq_done) begin
            err_d     = 1'b1;
            ctl_d.trk = 1'b0;
          end else begin
            ctl_d.trk = 1'b1;
          end
        end else begin
          ctl_d.trk = wr_track;
        end
        if (wr_bcs && !ctl_q.bcs) begin
          if (!ctl_q.trk || !trk_done) begin
            err_d     = 1'b1;
            ctl_d.bcs = 1'b0;
          end else begin
            ctl_d.bcs = 1'b1;
          end
        end else begin
          ctl_d.bcs = wr_bcs;
        end
        if (!ctl_d.trk) ctl_d.bcs = 1'b0;
      end
    end
    if (!ctl_d.on) begin
      ctl_d.trk = 1'b0;
      ctl_d.bcs = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      err_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      err_q <= err_d;
    end
  end

  assign pll_on  = ctl_q.on;
  assign track   = ctl_q.trk;
  assign bcs_sel = ctl_q.bcs;
  assign lock    = lock_q;
  assign irq     = irq_q;
  assign seq_err = err_q;

  // R9: the PLL clock is never selected while the PLL is off
  a_r9_bcs_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    bcs_sel |-> pll_on);
  // R8: in manual mode the PLL clock is selected only while tracking
  a_r8_bcs_needs_track: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.auto_md && bcs_sel) |-> track);
  // R7: entering tracking manually needs the acquisition delay expired
  a_r7_track_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q.auto_md && $rose(track)) |-> $past(acq_done));

endmodule

// File: tb/pll_sup_ctrl_test.sv
`timescale 1ns/1ps
module pll_sup_ctrl_test;

  localparam int unsigned DLY_W = 16;
  localparam int unsigned NV    = 12;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_pll_on, wr_auto, wr_track, wr_bcs, wr_irq_en, irq_ack, in_tol;
  logic [DLY_W-1:0] acq_delay, trk_delay;
  logic pll_on, track, lock, irq, bcs_sel, seq_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit fin    = 1'b0;

  always #4 clk = ~clk;

  pll_sup_ctrl #(.DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pll_on(wr_pll_on),
    .wr_auto(wr_auto), .wr_track(wr_track), .wr_bcs(wr_bcs),
    .wr_irq_en(wr_irq_en), .irq_ack(irq_ack), .acq_delay(acq_delay),
    .trk_delay(trk_delay), .in_tol(in_tol), .pll_on(pll_on), .track(track),
    .lock(lock), .irq(irq), .bcs_sel(bcs_sel), .seq_err(seq_err));

  // Vector: {on, auto, track, bcs, ie} write, then expected {pll_on, track, bcs_sel, seq_err}
  // Manual mode, acq_delay = 3, trk_delay = 2, writes on consecutive edges E0..E11.
  localparam logic [8:0] VEC [NV] = '{
    {5'b10100, 4'b1001},  // E0  R6 turn-on with tracking requested
    {5'b10100, 4'b1001},  // E1  R7 too early
    {5'b10000, 4'b1000},  // E2  idle write
    {5'b10100, 4'b1001},  // E3  R7 edge acq_delay: refused
    {5'b10100, 4'b1100},  // E4  R7 edge acq_delay+1: accepted
    {5'b10110, 4'b1101},  // E5  R8 too early
    {5'b10110, 4'b1101},  // E6  R8 edge trk_delay: refused
    {5'b10110, 4'b1110},  // E7  R8 edge trk_delay+1: accepted
    {5'b10010, 4'b1000},  // E8  R11 back to acquisition drops select
    {5'b00000, 4'b0000},  // E9  R9 off
    {5'b10000, 4'b1000},  // E10 on, acquisition
    {5'b10010, 4'b1001}   // E11 R8 select while acquiring refused
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drive at a negedge, sample edge follows, return at the next negedge
  task automatic wr(input logic on, input logic au, input logic tr,
                    input logic bc, input logic ie);
    wr_en = 1'b1; wr_pll_on = on; wr_auto = au; wr_track = tr;
    wr_bcs = bc; wr_irq_en = ie;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ack();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_pll_on = 1'b0; wr_auto = 1'b0;
    wr_track = 1'b0; wr_bcs = 1'b0; wr_irq_en = 1'b0; irq_ack = 1'b0;
    in_tol = 1'b0; acq_delay = 16'd3; trk_delay = 16'd2;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 reset outputs", {2'b0, pll_on, track, lock, irq, bcs_sel, seq_err}, 8'h00);

    // Vector table: manual sequencing R6 R7 R8 R11 R9
    for (int v = 0; v < NV; v++) begin
      wr(VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
      chk($sformatf("R6/R7/R8/R11 vector %0d", v),
          {4'b0, pll_on, track, bcs_sel, seq_err}, {4'b0, VEC[v][3:0]});
    end

    // Automatic mode, lock latency (R2), irq (R3), ack (R4)
    wr(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
    in_tol = 1'b1;
    idle(2);
    chk("R2 lock not yet after two edges", {7'b0, lock}, 8'h00);
    idle(1);
    chk("R2 lock after three edges", {7'b0, lock}, 8'h01);
    chk("R3 irq on lock set", {7'b0, irq}, 8'h01);
    chk("R10 track follows lock", {7'b0, track}, 8'h01);
    idle(4);
    chk("R4 irq sticky", {7'b0, irq}, 8'h01);
    ack();
    chk("R4 irq cleared by ack", {7'b0, irq}, 8'h00);
    in_tol = 1'b0;
    idle(3);
    chk("R3 lock clear and irq", {6'b0, lock, irq}, 8'h01);
    ack();
    wr(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R10 select accepted in automatic mode", {6'b0, bcs_sel, seq_err}, 8'h02);
    in_tol = 1'b1;
    idle(3);
    chk("R3 no irq when disabled", {6'b0, lock, irq}, 8'h02);

    // Manual mode suppresses lock and irq (R5)
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    idle(1);
    chk("R5 lock cleared in manual", {6'b0, lock, irq}, 8'h00);
    in_tol = 1'b0; idle(4); in_tol = 1'b1; idle(4);
    chk("R5 no lock or irq in manual", {6'b0, lock, irq}, 8'h00);

    // Power-off in automatic mode with lock and select (R9)
    wr(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    idle(3);
    chk("R9 setup locked and selected", {5'b0, lock, bcs_sel, track}, 8'h07);
    wr(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 off clears select and track", {5'b0, pll_on, bcs_sel, track}, 8'h00);
    idle(1);
    chk("R9 lock cleared after off", {7'b0, lock}, 8'h00);
    // Delay count restarted: manual turn-on then early tracking refused
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R9 acquisition delay restarted", {6'b0, track, seq_err}, 8'h01);
    idle(4);
    wr(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R7 tracking accepted after delay", {6'b0, track, seq_err}, 8'h02);

    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule